// File: doc/BRIEF.md
# Seeded Hough Intercept Clusterer

This block finds the straight-line segment in one drift-tube chamber when the track slope is already known from a coarse seed. Hits arrive one per stream beat. Each hit carries a tube-centre position along the chamber axis, the tube-centre height, and a drift radius. The seed slope and the path-length factor sqrt(1+m²) are held on sideband inputs for the whole segment. Each hit offers two line intercepts, one for each side of the wire. The block quantizes both to whole millimetres and sorts all of them. It then takes the longest run of closely spaced values as the segment.

After the last hit of a pretrigger, the block sorts and scans the candidates. It then pulses an interrupt and hands out a header word followed by one word per member candidate. A downstream least-squares fit reads these words and learns which hits to use and which side of each wire the track passed. The output uses a valid/ready word handshake. No new hits are accepted until the last word has been taken.

Positions are signed fixed point with 4 fractional bits (1/16 mm). The slope and the path-length factor carry 12 fractional bits.

Top module: `seg_hough_cluster`

## Requirements
- R1: For hit (z, y, r) with slope m and factor k, the two candidate intercepts are q± = floor((y − floor(m·z/4096) ± floor(k·r/4096)) / 16), in millimetres. The candidate with the + sign has side bit 0. The candidate with the − sign has side bit 1.
- R2: Candidates are ordered ascending by intercept, then by hit index, then by side bit. Member words appear in that order.
- R3: A cluster is a maximal run of consecutive sorted candidates in which each adjacent intercept difference is at most `clus_win`. The longest run is chosen. Between runs of equal length, the one with the lowest intercept wins. Header bits [5:0] give the chosen run length.
- R4: A member word carries the intercept in bits [31:16] (two's complement), the side bit in bit 8, and the hit index in bits [3:0]. All other bits are zero.
- R5: When the chosen run has fewer than 3 candidates, header bit 17 is set and no member words follow the header.
- R6: At most 16 hits per segment are kept. Hits are indexed 0 to 15 in arrival order. Beats after the sixteenth are accepted and discarded. If any beat was discarded, header bit 16 is set.
- R7: The header is the first word of each result. Bits [31:18] and [15:6] are zero. The header is followed by exactly as many member words as its count field when bit 17 is clear.
- R8: While `word_valid` is high and `word_ready` is low, `word_valid` and `word_data` hold steady.
- R9: `done_irq` is high for exactly one cycle per segment, in the first cycle the header is offered.
- R10: After reset, `hit_ready` is 1 and `word_valid` and `done_irq` are 0. `hit_ready` is 0 from the last hit beat until the final result word is taken, and never high together with `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_slope | input | 16 | Seeded slope m, signed, 12 fractional bits, stable for a segment |
| seed_norm | input | 16 | sqrt(1+m²), unsigned, 12 fractional bits, stable for a segment |
| clus_win | input | 8 | Largest adjacent intercept gap inside a cluster, in mm |
| hit_valid | input | 1 | Hit beat valid |
| hit_ready | output | 1 | Block accepts hit beats |
| hit_z | input | 16 | Tube-centre position along the chamber, signed, 1/16 mm |
| hit_y | input | 16 | Tube-centre height, signed, 1/16 mm |
| hit_r | input | 16 | Drift radius, unsigned, 1/16 mm |
| hit_last | input | 1 | Marks the final hit of the segment |
| word_valid | output | 1 | Result word valid |
| word_ready | input | 1 | Consumer takes the result word |
| word_data | output | 32 | Header or member word |
| done_irq | output | 1 | One-cycle pulse when a result is ready |

## Verification
The assertions assume three things about the inputs: the seed slope, the path-length factor and the window stay constant from the first hit beat until the header is taken; every segment has at least one beat; and intercepts fit the 16-bit key. The bench keeps every hit position within a few hundred millimetres and uses slopes below 1. This keeps all intercepts far inside the key range. It changes the sideband inputs only while the block is idle. It exercises tied runs, a zero window, overflow beyond sixteen hits and stalls on the output handshake.

// File: rtl/shc_pkg.sv
// Shared widths, candidate record and ordering for the seeded intercept clusterer.
// Assumes positions in 1/16 mm and slope/factor values with 12 fractional bits.
package shc_pkg;
    parameter int POS_W       = 16;
    parameter int POS_FRAC    = 4;
    parameter int SLOPE_W     = 16;
    parameter int SLOPE_FRAC  = 12;
    parameter int KEY_W       = 16;
    parameter int WIN_W       = 8;
    parameter int MAX_HITS    = 16;
    parameter int MIN_MEMBERS = 3;
    parameter int WORD_W      = 32;

    localparam int MAX_CAND = 2 * MAX_HITS;
    localparam int HIT_W    = $clog2(MAX_HITS);
    localparam int IDX_W    = $clog2(MAX_CAND);
    localparam int HCNT_W   = $clog2(MAX_HITS + 1);
    localparam int CNT_W    = $clog2(MAX_CAND + 1);

    typedef struct packed {
        logic                    valid;
        logic signed [KEY_W-1:0] key;
        logic [HIT_W-1:0]        idx;
        logic                    side;
    } cand_t;

    typedef enum logic [2:0] {
        ST_COLLECT = 3'd0,
        ST_SORT    = 3'd1,
        ST_SCAN    = 3'd2,
        ST_HDR     = 3'd3,
        ST_BODY    = 3'd4
    } fsm_t;

    // True when a must sit after b: empty slots last, then key, index, side.
    function automatic logic cand_gt(input cand_t a, input cand_t b);
        if (a.valid != b.valid) return b.valid;
        if (!a.valid)           return 1'b0;
        if (a.key != b.key)     return a.key > b.key;
        if (a.idx != b.idx)     return a.idx > b.idx;
        return a.side > b.side;
    endfunction
endpackage

// File: rtl/shc_vote.sv
// Combinational intercept vote: turns one hit into its two quantized intercepts.
// Assumes intercepts fit KEY_W whole millimetres; upper bits are dropped.
module shc_vote
    import shc_pkg::*;
(
    input  logic signed [POS_W-1:0]   z,
    input  logic signed [POS_W-1:0]   y,
    input  logic        [POS_W-1:0]   r,
    input  logic signed [SLOPE_W-1:0] slope,
    input  logic        [SLOPE_W-1:0] norm,
    output logic signed [KEY_W-1:0]   q_plus,
    output logic signed [KEY_W-1:0]   q_minus
);
    localparam int PRD_W = POS_W + SLOPE_W;
    localparam int EXT_W = PRD_W + 2;

    logic signed [PRD_W-1:0] mz_full;
    logic        [PRD_W-1:0] rk_full;
    logic signed [EXT_W-1:0] y_ext, mz_ext, rk_ext, b_plus, b_minus;

    // Products and unquantized intercepts for both wire sides.
    always_comb begin
        mz_full = slope * z;
        rk_full = norm * r;
        y_ext   = {{(EXT_W-POS_W){y[POS_W-1]}}, y};
        mz_ext  = {{(EXT_W-PRD_W){mz_full[PRD_W-1]}}, mz_full} >>> SLOPE_FRAC;
        rk_ext  = $signed({2'b00, rk_full} >> SLOPE_FRAC);
        b_plus  = y_ext - mz_ext + rk_ext;
        b_minus = y_ext - mz_ext - rk_ext;
    end

    assign q_plus  = b_plus[POS_FRAC +: KEY_W];
    assign q_minus = b_minus[POS_FRAC +: KEY_W];
endmodule

// File: rtl/shc_sorter.sv
// Candidate store with an odd-even transposition network, one pass per cycle.
// Assumes MAX_CAND passes after loading; writes land on an even slot pair.
module shc_sorter
    import shc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  cand_t            wr_a,
    input  cand_t            wr_b,
    input  logic             pass_en,
    input  logic             pass_odd,
    input  logic [IDX_W-1:0] rd_idx,
    output cand_t            rd_ent
);
    cand_t arr [MAX_CAND];
    cand_t nxt [MAX_CAND];
    logic  [MAX_CAND-2:0] swap_w;
    logic  [MAX_CAND-1:0] valid_vec;

    // One comparator per adjacent slot pair.
    for (genvar g = 0; g < MAX_CAND - 1; g++) begin : g_cmp
        assign swap_w[g] = cand_gt(arr[g], arr[g+1]);
    end

    for (genvar g = 0; g < MAX_CAND; g++) begin : g_vld
        assign valid_vec[g] = arr[g].valid;
    end

    // Next contents for one pass over the pairs of the selected parity.
    always_comb begin
        for (int i = 0; i < MAX_CAND; i++) nxt[i] = arr[i];
        for (int i = 0; i < MAX_CAND - 1; i++) begin
            if (pass_en && (((i % 2) == 1) == pass_odd) && swap_w[i]) begin
                nxt[i]   = arr[i+1];
                nxt[i+1] = arr[i];
            end
        end
    end

    // Storage update: clear, load a slot pair, or apply a sort pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < MAX_CAND; i++) arr[i] <= '0;
        end else if (wr_en) begin
            arr[wr_slot]      <= wr_a;
            arr[wr_slot + 1'b1] <= wr_b;
        end else begin
            for (int i = 0; i < MAX_CAND; i++) arr[i] <= nxt[i];
        end
    end

    assign rd_ent = arr[rd_idx];

    // A sort pass only permutes entries: the number of live candidates is kept.
    p_sort_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && !wr_en && !clr) |=> ($countones(valid_vec) == $countones($past(valid_vec))));
endmodule

// File: rtl/shc_runfind.sv
// Scans sorted candidates one per step and keeps the longest close-spaced run.
// Assumes steps arrive in ascending order after a clear; ties keep the earlier run.
module shc_runfind
    import shc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    step,
    input  logic signed [KEY_W-1:0] key,
    input  logic [WIN_W-1:0]        win,
    output logic [IDX_W-1:0]        best_start,
    output logic [CNT_W-1:0]        best_len
);
    logic signed [KEY_W-1:0] prev_key;
    logic [CNT_W-1:0]        pos, run_len, nrun_len;
    logic [IDX_W-1:0]        run_start, nrun_start;
    logic signed [KEY_W:0]   gap;
    logic                    joins;

    // Decide whether the current candidate extends the open run.
    always_comb begin
        gap   = {key[KEY_W-1], key} - {prev_key[KEY_W-1], prev_key};
        joins = (pos != '0) && (gap <= $signed({1'b0, {(KEY_W-WIN_W){1'b0}}, win}));
        if (joins) begin
            nrun_start = run_start;
            nrun_len   = run_len + 1'b1;
        end else begin
            nrun_start = pos[IDX_W-1:0];
            nrun_len   = CNT_W'(1);
        end
    end

    // Run tracking registers; a strictly longer run replaces the best one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_key   <= '0;
            pos        <= '0;
            run_len    <= '0;
            run_start  <= '0;
            best_len   <= '0;
            best_start <= '0;
        end else if (step) begin
            prev_key  <= key;
            pos       <= pos + 1'b1;
            run_len   <= nrun_len;
            run_start <= nrun_start;
            if (nrun_len > best_len) begin
                best_len   <= nrun_len;
                best_start <= nrun_start;
            end
        end
    end

    // The sorter must present non-decreasing intercepts.
    p_sorted_feed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && pos != '0) |-> (key >= prev_key));
    // The chosen run never holds more candidates than have been seen.
    p_best_within_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        best_len <= pos);
endmodule

// File: rtl/seg_hough_cluster.sv
// Top of the seeded intercept clusterer: collects hits, sorts their two votes,
// finds the densest intercept run and streams header plus member words.
// Assumes sideband seed inputs are steady from the first hit until the header
// is taken, and that each segment carries at least one beat.
module seg_hough_cluster
    import shc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SLOPE_W-1:0] seed_slope,
    input  logic [SLOPE_W-1:0]       seed_norm,
    input  logic [WIN_W-1:0]         clus_win,
    input  logic                     hit_valid,
    output logic                     hit_ready,
    input  logic signed [POS_W-1:0]  hit_z,
    input  logic signed [POS_W-1:0]  hit_y,
    input  logic [POS_W-1:0]         hit_r,
    input  logic                     hit_last,
    output logic                     word_valid,
    input  logic                     word_ready,
    output logic [WORD_W-1:0]        word_data,
    output logic                     done_irq
);
    localparam int SORT_PASSES = MAX_CAND;

    fsm_t              state;
    logic [HCNT_W-1:0] nhits;
    logic              ovf;
    logic [CNT_W-1:0]  pass_cnt, scan_ptr, body_cnt;
    logic [CNT_W-1:0]  ncand;
    logic [WIN_W-1:0]  win_q;
    logic signed [KEY_W-1:0] q_plus, q_minus;
    logic              take_hit, keep_hit, wr_en, pass_en, rf_clr, rf_step;
    logic              seg_done, no_seg, word_fire;
    logic [IDX_W-1:0]  rd_idx, best_start;
    logic [CNT_W-1:0]  best_len;
    cand_t             cand_a, cand_b, rd_ent;

    shc_vote u_vote (
        .z(hit_z), .y(hit_y), .r(hit_r),
        .slope(seed_slope), .norm(seed_norm),
        .q_plus(q_plus), .q_minus(q_minus)
    );

    // Handshake and control strobes derived from the current state.
    always_comb begin
        hit_ready = (state == ST_COLLECT);
        take_hit  = hit_ready && hit_valid;
        keep_hit  = take_hit && (nhits < HCNT_W'(MAX_HITS));
        wr_en     = keep_hit;
        pass_en   = (state == ST_SORT);
        rf_clr    = pass_en && (pass_cnt == CNT_W'(SORT_PASSES - 1));
        rf_step   = (state == ST_SCAN);
        ncand     = {nhits, 1'b0};
        no_seg    = best_len < CNT_W'(MIN_MEMBERS);
        word_valid = (state == ST_HDR) || (state == ST_BODY);
        word_fire  = word_valid && word_ready;
        seg_done   = word_fire && (((state == ST_HDR) && no_seg) ||
                     ((state == ST_BODY) && (body_cnt == best_len - 1'b1)));
        rd_idx     = (state == ST_BODY) ? (best_start + body_cnt[IDX_W-1:0])
                                        : scan_ptr[IDX_W-1:0];
    end

    // Candidate records for the two wire sides of the incoming hit.
    always_comb begin
        cand_a       = '0;
        cand_a.valid = 1'b1;
        cand_a.key   = q_plus;
        cand_a.idx   = nhits[HIT_W-1:0];
        cand_a.side  = 1'b0;
        cand_b       = cand_a;
        cand_b.key   = q_minus;
        cand_b.side  = 1'b1;
    end

    shc_sorter u_sort (
        .clk(clk), .rst_n(rst_n), .clr(seg_done),
        .wr_en(wr_en), .wr_slot({nhits[HIT_W-1:0], 1'b0}),
        .wr_a(cand_a), .wr_b(cand_b),
        .pass_en(pass_en), .pass_odd(pass_cnt[0]),
        .rd_idx(rd_idx), .rd_ent(rd_ent)
    );

    shc_runfind u_run (
        .clk(clk), .rst_n(rst_n), .clr(rf_clr), .step(rf_step),
        .key(rd_ent.key), .win(win_q),
        .best_start(best_start), .best_len(best_len)
    );

    // Output word formatting for header and member words.
    always_comb begin
        word_data = '0;
        if (state == ST_HDR) begin
            word_data[5:0] = best_len;
            word_data[16]  = ovf;
            word_data[17]  = no_seg;
        end else if (state == ST_BODY) begin
            word_data[31:16] = rd_ent.key;
            word_data[8]     = rd_ent.side;
            word_data[3:0]   = rd_ent.idx;
        end
    end

    // Segment sequencing: collect, sort passes, scan, then hand out words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_COLLECT;
            nhits    <= '0;
            ovf      <= 1'b0;
            pass_cnt <= '0;
            scan_ptr <= '0;
            body_cnt <= '0;
            win_q    <= '0;
            done_irq <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            case (state)
                ST_COLLECT: begin
                    if (keep_hit) nhits <= nhits + 1'b1;
                    if (take_hit && !keep_hit) ovf <= 1'b1;
                    if (take_hit && hit_last) begin
                        state    <= ST_SORT;
                        pass_cnt <= '0;
                        win_q    <= clus_win;
                    end
                end
                ST_SORT: begin
                    pass_cnt <= pass_cnt + 1'b1;
                    if (rf_clr) begin
                        state    <= ST_SCAN;
                        scan_ptr <= '0;
                    end
                end
                ST_SCAN: begin
                    scan_ptr <= scan_ptr + 1'b1;
                    if (scan_ptr == ncand - 1'b1) begin
                        state    <= ST_HDR;
                        done_irq <= 1'b1;
                    end
                end
                ST_HDR: begin
                    if (word_fire && !no_seg) begin
                        state    <= ST_BODY;
                        body_cnt <= '0;
                    end
                end
                ST_BODY: begin
                    if (word_fire) body_cnt <= body_cnt + 1'b1;
                end
                default: state <= ST_COLLECT;
            endcase
            if (seg_done) begin
                state <= ST_COLLECT;
                nhits <= '0;
                ovf   <= 1'b0;
            end
        end
    end

    // A stalled word must not change or vanish.
    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
    // The completion interrupt is a single-cycle pulse.
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    // The interrupt coincides with the header being offered.
    p_irq_with_header_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (word_valid && word_data[31:18] == '0));
    // The stored hit count never passes the chamber limit.
    p_hit_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nhits <= HCNT_W'(MAX_HITS));
    // Input and output sides are never open at once.
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_ready && word_valid));
endmodule

// File: tb/sim_seg_hough_cluster.sv
module sim_seg_hough_cluster;
    import shc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [15:0] seed_slope = '0;
    logic [15:0] seed_norm = 16'd4096;
    logic [7:0]  clus_win = 8'd1;
    logic hit_valid = 1'b0, hit_last = 1'b0, word_ready = 1'b0;
    logic signed [15:0] hit_z = '0, hit_y = '0;
    logic [15:0] hit_r = '0;
    logic hit_ready, word_valid, done_irq;
    logic [31:0] word_data;

    always #2 clk = ~clk;

    seg_hough_cluster u0 (
        .clk(clk), .rst_n(rst_n), .seed_slope(seed_slope), .seed_norm(seed_norm),
        .clus_win(clus_win), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_z(hit_z), .hit_y(hit_y), .hit_r(hit_r), .hit_last(hit_last),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .done_irq(done_irq)
    );

    typedef struct packed {
        logic signed [15:0] slope;
        logic [15:0] norm;
        logic [7:0]  win;
        logic [4:0]  ntrk;
        logic [4:0]  nnoise;
        logic [31:0] seed;
        logic        rmode;
    } case_t;

    localparam int NCASES = 6;
    localparam case_t CASES [NCASES] = '{
        '{16'sd0,     16'd4096, 8'd1, 5'd6,  5'd2,  32'd11, 1'b0},
        '{16'sd1024,  16'd4222, 8'd1, 5'd8,  5'd4,  32'd23, 1'b1},
        '{-16'sd2048, 16'd4579, 8'd2, 5'd5,  5'd5,  32'd37, 1'b0},
        '{16'sd512,   16'd4128, 8'd0, 5'd7,  5'd3,  32'd41, 1'b1},
        '{16'sd3072,  16'd5120, 8'd3, 5'd10, 5'd6,  32'd53, 1'b0},
        '{16'sd0,     16'd4096, 8'd1, 5'd2,  5'd10, 32'd67, 1'b1}
    };

    int n_chk = 0, n_bad = 0, irq_cnt = 0;
    int h_z [20], h_y [20], h_r [20];
    logic [31:0] exp_w [33];
    int exp_n;
    logic [31:0] got_w [40];
    int got_n;
    logic [31:0] lcg;

    always @(negedge clk) if (done_irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'(lcg[30:16]) % m;
    endfunction

    // Reference result built from the requirement text.
    task automatic build_ref(input int nh, input int slope, input int norm, input int win);
        longint q [32];
        int ix [32], sd [32];
        int nk, nc, rs, rl, bs, bl;
        bit ovf, nos;
        nk = (nh > 16) ? 16 : nh;
        ovf = (nh > 16);
        nc = 2 * nk;
        for (int i = 0; i < nk; i++) begin
            longint mz, rk, bp, bm;
            mz = (longint'(slope) * longint'(h_z[i])) >>> 12;
            rk = (longint'(norm) * longint'(h_r[i])) >>> 12;
            bp = longint'(h_y[i]) - mz + rk;
            bm = longint'(h_y[i]) - mz - rk;
            q[2*i] = bp >>> 4;     ix[2*i] = i;   sd[2*i] = 0;
            q[2*i+1] = bm >>> 4;   ix[2*i+1] = i; sd[2*i+1] = 1;
        end
        for (int a = 0; a < nc; a++) begin
            for (int b = 0; b + 1 < nc - a; b++) begin
                bit sw;
                sw = (q[b] > q[b+1]) || (q[b] == q[b+1] && ix[b] > ix[b+1]) ||
                     (q[b] == q[b+1] && ix[b] == ix[b+1] && sd[b] > sd[b+1]);
                if (sw) begin
                    longint tq; int ti, ts;
                    tq = q[b]; q[b] = q[b+1]; q[b+1] = tq;
                    ti = ix[b]; ix[b] = ix[b+1]; ix[b+1] = ti;
                    ts = sd[b]; sd[b] = sd[b+1]; sd[b+1] = ts;
                end
            end
        end
        rs = 0; rl = 0; bs = 0; bl = 0;
        for (int p = 0; p < nc; p++) begin
            if (p == 0 || q[p] - q[p-1] > win) begin rs = p; rl = 1; end
            else rl++;
            if (rl > bl) begin bl = rl; bs = rs; end
        end
        nos = (bl < 3);
        exp_w[0] = (32'(nos) << 17) | (32'(ovf) << 16) | 32'(bl);
        exp_n = 1;
        if (!nos) begin
            for (int k = 0; k < bl; k++) begin
                exp_w[exp_n] = ((32'(q[bs+k]) & 32'hFFFF) << 16) | (32'(sd[bs+k]) << 8) | 32'(ix[bs+k]);
                exp_n++;
            end
        end
    endtask

    task automatic send_hits(input int nh);
        for (int i = 0; i < nh; i++) begin
            @(negedge clk);
            hit_valid = 1'b1;
            hit_z = 16'(h_z[i]); hit_y = 16'(h_y[i]); hit_r = 16'(h_r[i]);
            hit_last = (i == nh - 1);
            #1;
            while (!hit_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        hit_valid = 1'b0; hit_last = 1'b0;
    endtask

    task automatic collect(input bit rmode);
        int cyc, need;
        cyc = 0; got_n = 0; need = 1;
        while (got_n < need) begin
            @(negedge clk);
            word_ready = rmode ? cyc[0] : 1'b1;
            cyc++;
            #1;
            if (word_valid && word_ready) begin
                if (got_n == 0) begin
                    chk(!hit_ready, "R10 input closed while result pending", hit_ready, 0);
                    need = word_data[17] ? 1 : 1 + int'(word_data[5:0]);
                end
                got_w[got_n] = word_data;
                got_n++;
            end
        end
        @(negedge clk);
        word_ready = 1'b0;
        #1;
        chk(hit_ready && !word_valid, "R10 idle again after last word", {hit_ready, word_valid}, 2'b10);
    endtask

    task automatic run_seg(input int nh, input int slope, input int norm, input int win, input bit rmode);
        int irq0;
        seed_slope = 16'(slope); seed_norm = 16'(norm); clus_win = 8'(win);
        build_ref(nh, slope, norm, win);
        irq0 = irq_cnt;
        send_hits(nh);
        collect(rmode);
        chk(irq_cnt == irq0 + 1, "R9 one interrupt per segment", irq_cnt - irq0, 1);
        chk(got_n == exp_n, rmode ? "R8 word count under stalls" : "R7 word count", got_n, exp_n);
        chk(got_w[0][5:0] == exp_w[0][5:0], "R3 run length", got_w[0][5:0], exp_w[0][5:0]);
        chk(got_w[0][31:6] == exp_w[0][31:6], "R7 header flags", got_w[0], exp_w[0]);
        for (int k = 1; k < got_n && k < exp_n; k++) begin
            chk(got_w[k][31:16] == exp_w[k][31:16], "R1 member intercept", got_w[k][31:16], exp_w[k][31:16]);
            chk(got_w[k][15:0] == exp_w[k][15:0], "R4 member side/index", got_w[k][15:0], exp_w[k][15:0]);
            if (k > 1)
                chk($signed(got_w[k][31:16]) >= $signed(got_w[k-1][31:16]), "R2 ascending members",
                    got_w[k][31:16], got_w[k-1][31:16]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(hit_ready == 1'b1, "R10 reset hit_ready", hit_ready, 1);
        chk(word_valid == 1'b0 && done_irq == 1'b0, "R10 reset outputs", {word_valid, done_irq}, 0);

        // Table of generated segments.
        for (int c = 0; c < NCASES; c++) begin
            int nt, nn, b0;
            nt = int'(CASES[c].ntrk); nn = int'(CASES[c].nnoise);
            lcg = CASES[c].seed;
            b0 = 1200 + rnd(800);
            for (int i = 0; i < nt + nn; i++) begin
                if (i < nt) begin
                    longint mz, rk;
                    h_z[i] = i * 600 + rnd(64);
                    h_r[i] = rnd(240);
                    mz = (longint'(CASES[c].slope) * longint'(h_z[i])) >>> 12;
                    rk = (longint'(CASES[c].norm) * longint'(h_r[i])) >>> 12;
                    h_y[i] = b0 + int'(mz) - int'(rk) + rnd(8);
                end else begin
                    h_z[i] = rnd(4800); h_y[i] = rnd(6400); h_r[i] = rnd(240);
                end
            end
            run_seg(nt + nn, int'(CASES[c].slope), int'(CASES[c].norm), int'(CASES[c].win), CASES[c].rmode);
        end

        // R5: a single hit cannot form a segment.
        h_z[0] = 0; h_y[0] = 1600; h_r[0] = 200;
        run_seg(1, 0, 4096, 1, 1'b0);
        chk(got_w[0] == ((32'd1 << 17) | 32'd1), "R5 no-segment header", got_w[0], (32'd1 << 17) | 32'd1);
        chk(got_n == 1, "R5 no member words", got_n, 1);

        // R3: two equal runs, the lower intercept wins.
        h_z[0] = 0;  h_y[0] = 800; h_r[0] = 0;
        h_z[1] = 16; h_y[1] = 800; h_r[1] = 0;
        h_z[2] = 0;  h_y[2] = 160; h_r[2] = 0;
        h_z[3] = 32; h_y[3] = 160; h_r[3] = 0;
        run_seg(4, 0, 4096, 1, 1'b0);
        chk(got_w[0][5:0] == 6'd4, "R3 tie length", got_w[0][5:0], 4);
        chk(got_w[1] == ((32'd10 << 16) | 32'd2), "R3 tie picks lowest intercept", got_w[1], (32'd10 << 16) | 32'd2);

        // Window zero versus one on keys 10,10,10,10,11,11.
        h_z[0] = 0; h_y[0] = 160; h_r[0] = 0;
        h_z[1] = 0; h_y[1] = 165; h_r[1] = 0;
        h_z[2] = 0; h_y[2] = 176; h_r[2] = 0;
        run_seg(3, 0, 4096, 0, 1'b1);
        chk(got_w[0][5:0] == 6'd4, "R3 zero window splits", got_w[0][5:0], 4);
        run_seg(3, 0, 4096, 1, 1'b0);
        chk(got_w[0][5:0] == 6'd6, "R3 unit window joins", got_w[0][5:0], 6);

        // R6: eighteen beats, only sixteen kept.
        for (int i = 0; i < 18; i++) begin
            h_z[i] = i * 100; h_y[i] = (i < 16) ? 1600 + 4 * i : 1600; h_r[i] = 16 * (i % 5);
        end
        run_seg(18, 0, 4096, 1, 1'b1);
        chk(got_w[0][16] == 1'b1, "R6 overflow flag", got_w[0][16], 1);
        for (int k = 1; k < got_n; k++)
            chk(got_w[k][3:0] <= 4'd15 && got_w[k][7:4] == 4'd0, "R6 kept index range", got_w[k][7:0], 15);

        // R6: flag clears on the next segment.
        h_z[0] = 0; h_y[0] = 160; h_r[0] = 0;
        h_z[1] = 0; h_y[1] = 160; h_r[1] = 0;
        run_seg(2, 0, 4096, 1, 1'b0);
        chk(got_w[0][16] == 1'b0, "R6 overflow cleared", got_w[0][16], 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule